// File: doc/BRIEF.md
# DMA Request Pin Activation Sequencer

This block turns an external active-low DMA request pin into single transfer-start pulses for one DMA channel. The pin is resynchronised and then tracked by a three-step handshake. The first step waits for a low level. The second waits for the datapath to report that a transfer slot is free, and issues the start pulse. The third waits for the pin to be seen high again before the sequencer re-arms. The block fires once per low period of the pin. Because enabling the channel places the sequencer straight into the wait-for-low step, a pin that is already low at enable time produces an activation without any edge.

The block also holds the channel's control register. That register carries the enable, the interrupt enable, the interrupt flag and three output-pin enables. The block also holds a module-stop bit, which deasserts the block's clock enable. Setting the stop bit is refused while the channel is enabled or an interrupt is pending. While the block is stopped, the control register reads as zero and ignores writes. The pin enables keep driving their outputs during that time. The stop register stays accessible.

Top module: `dreq_activation_seq`

## Requirements
- R1: A synchronous active-high reset clears the enable, interrupt enable, interrupt flag, pin enables and stop bit, leaves the sequencer idle, and drives the start pulse and the interrupt low and the clock enable high.
- R2: The request pin passes through a two-flop synchronizer. While armed, a low synchronized level moves the sequencer to the slot-wait step.
- R3: In the slot-wait step the sequencer waits for `xfer_ready`. On the edge where it is high, the sequencer raises `xfer_start` for exactly one cycle and moves to the re-arm step. No start pulse is issued while `xfer_ready` is low.
- R4: In the re-arm step no further start is issued until the synchronized pin has been seen high. After that, the sequencer is armed again, so each low period of the pin yields exactly one start.
- R5: A control write that sets the enable (bit 0 of address 0) on a disabled channel arms the sequencer. With the pin already low and `xfer_ready` high, `xfer_start` is high in the second cycle after the write edge.
- R6: While the channel is enabled, control writes (address 0) are ignored, except that a write with bit 0 at zero clears the enable. Clearing the enable returns the sequencer to idle from any step and suppresses any pending start.
- R7: Writing 1 to bit 0 of address 1 sets the stop bit only when the channel is disabled and no interrupt is pending. Writing 0 to it always clears it.
- R8: While stopped, `clk_en` is low, reads of address 0 return zero, and writes to address 0 are ignored. Address 1 reads back the stop bit in bit 0.
- R9: The three pin enables (bits 3, 4, 5 of address 0) drive `end_pin_en`, `rak_pin_en` and `ack_pin_en`, and keep their values while stopped.
- R10: `xfer_done` on an enabled channel sets the interrupt flag (bit 2). `irq` is flag AND interrupt enable (bit 1). On a disabled channel, writing 0 to either bit clears `irq`, and writing 1 to the flag has no effect.
- R11: Reads are registered: `rd_data` shows the register selected by `rd_addr` one cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 1 | Raw active-low request pin |
| xfer_ready | input | 1 | Datapath can perform a transfer |
| xfer_done | input | 1 | Datapath finished a transfer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address (0 control, 1 stop) |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Registered read data |
| xfer_start | output | 1 | One-cycle transfer start pulse |
| irq | output | 1 | Interrupt request |
| stopped | output | 1 | Module-stop status |
| clk_en | output | 1 | Internal clock enable |
| end_pin_en | output | 1 | End-of-transfer pin enable |
| rak_pin_en | output | 1 | Request-acknowledge pin enable |
| ack_pin_en | output | 1 | Access-acknowledge pin enable |

## Verification
A sequencer stuck in the re-arm step shows up as a missing start after the pin's next high-then-low period. One that skips re-arm shows up as repeated pulses while the pin is held low. Both are visible within about four cycles of the pin change. A wrong enable or stop bit shows on the next edge, through the stop status, through a start that should have been suppressed, or through a register read one cycle later. The stop-acceptance rule is swept over every combination of enable, interrupt enable and flag.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ARMED = 2'd1,
    SQ_SLOT  = 2'd2,
    SQ_REARM = 2'd3
  } seq_state_e;

  // control register field positions (address 0)
  localparam int unsigned F_EN  = 0;
  localparam int unsigned F_IE  = 1;
  localparam int unsigned F_FL  = 2;
  localparam int unsigned F_END = 3;
  localparam int unsigned F_RAK = 4;
  localparam int unsigned F_ACK = 5;
  localparam int unsigned CTL_FIELDS = 6;
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dreq_seq.sv
module dreq_seq
  import dreq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       arm,
  input  logic       kill,
  input  logic       pin_low,
  input  logic       xfer_ready,
  output logic       xfer_start,
  output seq_state_e state
);
  seq_state_e state_n;
  logic       start_n;

  always_comb begin
    state_n = state;
    start_n = 1'b0;
    if (kill) begin
      state_n = SQ_IDLE;
    end else if (arm) begin
      state_n = SQ_ARMED;
    end else begin
      case (state)
        SQ_ARMED: if (pin_low) state_n = SQ_SLOT;
        SQ_SLOT: if (xfer_ready) begin
          state_n = SQ_REARM;
          start_n = 1'b1;
        end
        SQ_REARM: if (!pin_low) state_n = SQ_ARMED;
        default: state_n = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      xfer_start <= 1'b0;
    end else if (run) begin
      state      <= state_n;
      xfer_start <= start_n;
    end else begin
      xfer_start <= 1'b0;
    end
  end
endmodule

// File: rtl/dreq_ctrl.sv
module dreq_ctrl
  import dreq_pkg::*;
#(
  parameter int unsigned AW = 1,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  input  logic          xfer_done,
  output logic [DW-1:0] rd_data,
  output logic          chan_en,
  output logic          arm,
  output logic          kill,
  output logic          irq,
  output logic          stopped,
  output logic          clk_en,
  output logic [2:0]    pin_en
);
  localparam logic [AW-1:0] CTL_ADDR  = AW'(0);
  localparam logic [AW-1:0] STOP_ADDR = AW'(1);

  logic       ie_q, fl_q;
  logic       en_n, ie_n, fl_n, ms_n;
  logic [2:0] pins_n;
  logic       ctl_wr, stop_wr;

  assign ctl_wr  = wr_en && (wr_addr == CTL_ADDR) && !stopped;
  assign stop_wr = wr_en && (wr_addr == STOP_ADDR);
  assign arm     = ctl_wr && !chan_en && wr_data[F_EN];
  assign kill    = ctl_wr && chan_en && !wr_data[F_EN];

  always_comb begin
    en_n   = chan_en;
    ie_n   = ie_q;
    fl_n   = fl_q;
    pins_n = pin_en;
    ms_n   = stopped;
    if (ctl_wr) begin
      if (chan_en) begin
        if (!wr_data[F_EN]) en_n = 1'b0;
      end else begin
        en_n   = wr_data[F_EN];
        ie_n   = wr_data[F_IE];
        fl_n   = fl_q & wr_data[F_FL];
        pins_n = {wr_data[F_ACK], wr_data[F_RAK], wr_data[F_END]};
      end
    end
    if (chan_en && xfer_done && !stopped) fl_n = 1'b1;
    if (stop_wr) begin
      if (!wr_data[0]) ms_n = 1'b0;
      else if (!chan_en && !(fl_q && ie_q)) ms_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_en <= 1'b0;
      ie_q    <= 1'b0;
      fl_q    <= 1'b0;
      pin_en  <= '0;
      stopped <= 1'b0;
      clk_en  <= 1'b1;
      irq     <= 1'b0;
      rd_data <= '0;
    end else begin
      chan_en <= en_n;
      ie_q    <= ie_n;
      fl_q    <= fl_n;
      pin_en  <= pins_n;
      stopped <= ms_n;
      clk_en  <= !ms_n;
      irq     <= fl_n && ie_n;
      if (rd_addr == CTL_ADDR)
        rd_data <= stopped ? '0
                 : DW'({pin_en[2], pin_en[1], pin_en[0], fl_q, ie_q, chan_en});
      else if (rd_addr == STOP_ADDR)
        rd_data <= DW'(stopped);
      else
        rd_data <= '0;
    end
  end
endmodule

// File: rtl/dreq_activation_seq.sv
module dreq_activation_seq
  import dreq_pkg::*;
#(
  parameter int unsigned AW          = 1,
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_n,
  input  logic          xfer_ready,
  input  logic          xfer_done,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          xfer_start,
  output logic          irq,
  output logic          stopped,
  output logic          clk_en,
  output logic          end_pin_en,
  output logic          rak_pin_en,
  output logic          ack_pin_en
);
  logic       req_sync, chan_en, arm, kill;
  logic [2:0] pin_en;
  seq_state_e seq_state;

  dreq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk), .rst (rst), .d (req_n), .q (req_sync)
  );

  dreq_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .rd_addr (rd_addr), .xfer_done (xfer_done),
    .rd_data (rd_data), .chan_en (chan_en), .arm (arm), .kill (kill),
    .irq (irq), .stopped (stopped), .clk_en (clk_en), .pin_en (pin_en)
  );

  dreq_seq u_seq (
    .clk (clk), .rst (rst), .run (clk_en), .arm (arm), .kill (kill),
    .pin_low (!req_sync), .xfer_ready (xfer_ready),
    .xfer_start (xfer_start), .state (seq_state)
  );

  assign end_pin_en = pin_en[0];
  assign rak_pin_en = pin_en[1];
  assign ack_pin_en = pin_en[2];
endmodule

// File: rtl/dreq_checker.sv
module dreq_checker #(
  parameter int unsigned AW = 1,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          xfer_ready,
  input logic          xfer_done,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [AW-1:0] rd_addr,
  input logic [DW-1:0] rd_data,
  input logic          xfer_start,
  input logic          irq,
  input logic          stopped,
  input logic          chan_en
);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start);

  a_r3_start_needs_slot: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> $past(xfer_ready));

  a_r6_disabled_no_start: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> !xfer_start);

  a_r7_stop_refused: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == AW'(1) && wr_data[0] && (chan_en || irq) && !stopped)
      |=> !stopped);

  a_r8_stopped_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (stopped && rd_addr == AW'(0)) |=> rd_data == '0);

  a_r10_irq_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(xfer_done) || $past(wr_en)));
endmodule

bind dreq_activation_seq dreq_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk (clk), .rst (rst), .xfer_ready (xfer_ready), .xfer_done (xfer_done),
  .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data), .rd_addr (rd_addr),
  .rd_data (rd_data), .xfer_start (xfer_start), .irq (irq),
  .stopped (stopped), .chan_en (chan_en)
);

// File: tb/tb_dreq_activation_seq.sv
module tb_dreq_activation_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_n = 1'b1, xfer_ready = 1'b0, xfer_done = 1'b0;
  logic       wr_en = 1'b0;
  logic [0:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic       xfer_start, irq, stopped, clk_en, end_pin_en, rak_pin_en, ack_pin_en;
  int         checks = 0, fails = 0, pulses = 0;
  bit         finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dreq_activation_seq dut (
    .clk (clk), .rst (rst), .req_n (req_n), .xfer_ready (xfer_ready),
    .xfer_done (xfer_done), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
    .xfer_start (xfer_start), .irq (irq), .stopped (stopped),
    .clk_en (clk_en), .end_pin_en (end_pin_en), .rak_pin_en (rak_pin_en),
    .ack_pin_en (ack_pin_en)
  );

  always @(posedge clk) if (xfer_start) pulses <= pulses + 1;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, input string tag, input int exp);
    rd_addr = a;
    tick(1);
    chk(tag, rd_data, exp);
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(2); rst = 1'b0; tick(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int p;
    tick(1);
    do_reset();
    // R1 reset state
    chk("R1 start", xfer_start, 0);
    chk("R1 irq", irq, 0);
    chk("R1 stopped", stopped, 0);
    chk("R1 clk_en", clk_en, 1);
    rd(1'b0, "R1 R11 ctl read", 0);

    // R5 / R2: pin already low at enable
    req_n = 1'b0; xfer_ready = 1'b1; tick(4);
    wr(1'b0, 8'h01);
    tick(1); chk("R5 no start yet", xfer_start, 0);
    tick(1); chk("R5 R2 start on level", xfer_start, 1);
    tick(1); chk("R3 single cycle", xfer_start, 0);
    p = pulses;
    tick(10); chk("R4 held low no refire", pulses, p);

    // R4 sweep: each high-then-low period gives one start
    for (int k = 1; k <= 5; k++) begin
      req_n = 1'b1; tick(3 + k % 2);
      req_n = 1'b0; tick(6);
      chk("R4 one start per low period", pulses, p + k);
    end

    // R3 slot wait
    xfer_ready = 1'b0; req_n = 1'b1; tick(4);
    req_n = 1'b0; p = pulses; tick(8);
    chk("R3 no start without slot", pulses, p);
    xfer_ready = 1'b1; tick(1);
    chk("R3 start when slot", xfer_start, 1);

    // R6 writes ignored while enabled, disable suppresses start
    wr(1'b0, 8'h0B);
    rd(1'b0, "R6 config ignored", 8'h01);
    xfer_ready = 1'b0; req_n = 1'b1; tick(4);
    req_n = 1'b0; tick(4);
    p = pulses;
    wr(1'b0, 8'h00);
    xfer_ready = 1'b1; tick(6);
    chk("R6 pending start suppressed", pulses, p);
    rd(1'b0, "R6 enable cleared", 0);

    // R10 / R7 interrupt and stop refusal
    xfer_ready = 1'b0; req_n = 1'b1;
    wr(1'b0, 8'h03);
    xfer_done = 1'b1; tick(1); xfer_done = 1'b0;
    chk("R10 irq raised", irq, 1);
    wr(1'b1, 8'h01);
    chk("R7 refused while enabled", stopped, 0);
    wr(1'b0, 8'h06);
    chk("R10 irq kept", irq, 1);
    wr(1'b1, 8'h01);
    chk("R7 refused while irq pending", stopped, 0);
    wr(1'b0, 8'h02);
    chk("R10 flag clear drops irq", irq, 0);

    // R8 / R9 stop behaviour
    wr(1'b0, 8'h38);
    wr(1'b1, 8'h01);
    chk("R7 stop accepted", stopped, 1);
    chk("R8 clk_en low", clk_en, 0);
    chk("R9 end pin kept", end_pin_en, 1);
    chk("R9 rak pin kept", rak_pin_en, 1);
    chk("R9 ack pin kept", ack_pin_en, 1);
    rd(1'b0, "R8 ctl reads zero", 0);
    rd(1'b1, "R8 stop readable", 1);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h00);
    chk("R7 stop cleared", stopped, 0);
    rd(1'b0, "R8 write ignored while stopped", 8'h38);

    // R7 / R10 sweep over enable, interrupt enable, flag
    for (int c = 0; c < 8; c++) begin
      logic en, ie, fl;
      en = c[0]; ie = c[1]; fl = c[2];
      do_reset();
      if (fl) begin
        wr(1'b0, 8'h03);
        xfer_done = 1'b1; tick(1); xfer_done = 1'b0;
        wr(1'b0, 8'h00);
      end
      wr(1'b0, {5'b0, fl, ie, 1'b0});
      if (en) wr(1'b0, {5'b0, fl, ie, 1'b1});
      chk("R10 irq sweep", irq, int'(ie && fl));
      wr(1'b1, 8'h01);
      chk("R7 stop sweep", stopped, int'(!en && !(ie && fl)));
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule